// File: doc/BRIEF.md
# Stream-to-Memory DMA Writer

This block moves a fixed-size block of words from a ready/valid input stream into system memory. It acts as an AXI4 write master. Software programs a destination base address and an enable bit through a small AXI4-Lite register file. While the engine is enabled and idle, it starts a run at the base address. It writes `DATA_LEN` words as a sequence of INCR bursts, and no burst is longer than `MAX_BURST` beats. A run ends only after every burst of the run has been acknowledged on the write-response channel.

Software controls the engine with the enable bit and the idle flag. If software clears the enable bit while a run is in flight, the run still writes every word of the block and collects every response. The engine then parks in idle. This gives software a simple way to synchronise. One option is to enable the engine and wait for idle to drop and then rise, then read the buffer. The other is to keep the engine enabled and disable it only while the buffer is being read.

Top module: `stream_dma_writer`

## Requirements
- R1: After reset, the control register reads 0x2 (enable 0, idle 1), and `st_ready`, `m_awvalid` and `m_wvalid` are all low.
- R2: Control register at offset 0x0: bit 0 is read/write enable, and bit 1 is a read-only idle flag. A write to bit 1 changes nothing.
- R3: Base-address register at offset 0x4 is read/write over its full width. Any other offset reads as 0.
- R4: While the engine is enabled and idle, it starts a run without further stimulus. While a run is pending, the idle flag reads 0.
- R5: Each burst carries min(remaining words, `MAX_BURST`) beats, with `m_awlen` = beats−1, `m_awburst` = 2'b01 (INCR) and `m_awsize` = log2(bytes per word). The address and length stay stable while `m_awvalid` waits for `m_awready`.
- R6: The first burst of a run targets the base address. Each later burst is placed `MAX_BURST`×bytes-per-word above the previous one.
- R7: Write data leaves in stream order with all strobes set. `m_wlast` is high exactly on the final beat of each burst, and `m_wvalid` is only raised inside a burst whose address has been accepted.
- R8: `st_ready` is low unless a burst's data phase is being fed. This covers the engine being off and idle, and the wait for the address handshake.
- R9: The idle flag returns to 1 only after one write response per burst of the run has been received.
- R10: Clearing enable mid-run does not cut the run short. All `DATA_LEN` words are written, and the engine then stays idle with no further address request.
- R11: If enable is still set when a run completes, the next run starts again at the base address.
- R12: Each register write gets exactly one OKAY (2'b00) response. Read data and read valid hold steady until `cfg_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_awaddr | input | LITE_AW | Register write address |
| cfg_awvalid | input | 1 | Register write address valid |
| cfg_awready | output | 1 | Register write address ready |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_wvalid | input | 1 | Register write data valid |
| cfg_wready | output | 1 | Register write data ready |
| cfg_bresp | output | 2 | Register write response (always OKAY) |
| cfg_bvalid | output | 1 | Register write response valid |
| cfg_bready | input | 1 | Register write response ready |
| cfg_araddr | input | LITE_AW | Register read address |
| cfg_arvalid | input | 1 | Register read address valid |
| cfg_arready | output | 1 | Register read address ready |
| cfg_rdata | output | ADDR_W | Register read data |
| cfg_rresp | output | 2 | Register read response (always OKAY) |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rready | input | 1 | Register read data ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats in burst minus one |
| m_awsize | output | 3 | log2 of bytes per beat |
| m_awburst | output | 2 | Burst type, INCR |
| m_awvalid | output | 1 | Burst address valid |
| m_awready | input | 1 | Burst address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes, all set |
| m_wlast | output | 1 | Final beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready, always high |
| st_data | input | DATA_W | Input stream word |
| st_valid | input | 1 | Input stream valid |
| st_ready | output | 1 | Input stream ready |

## Verification
Two events can land in the same clock cycle. A write response for an earlier burst can arrive while the next burst's address handshake or final data beat is happening. Software can also clear enable in the same window in which the run's last response lands. The bench sweeps the write-response delay, the address-ready phase and the data-ready pattern over a small configuration (10 words, bursts of at most 4), so that responses overlap the later address and data phases on many alignments. Each run is judged arithmetically in two ways. The bench counts words and responses between the enable write and the moment idle reads back 1. It also tracks every address and length against the expected base plus burst index times the stride.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } dma_state_t;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int ADDR_W  = 32,
  parameter int LITE_AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LITE_AW-1:0] awaddr,
  input  logic               awvalid,
  output logic               awready,
  input  logic [ADDR_W-1:0]  wdata,
  input  logic               wvalid,
  output logic               wready,
  output logic               bvalid,
  input  logic               bready,
  input  logic [LITE_AW-1:0] araddr,
  input  logic               arvalid,
  output logic               arready,
  output logic [ADDR_W-1:0]  rdata,
  output logic               rvalid,
  input  logic               rready,
  input  logic               idle,
  output logic               enable,
  output logic [ADDR_W-1:0]  base
);
  localparam logic [LITE_AW-1:0] OFS_CTRL = LITE_AW'(0);
  localparam logic [LITE_AW-1:0] OFS_BASE = LITE_AW'(4);

  logic              en_q, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0] base_q, rdata_q;
  logic              wr_fire, rd_fire;

  assign wr_fire = awvalid && wvalid && !bvalid_q;
  assign rd_fire = arvalid && !rvalid_q;
  assign awready = wvalid && !bvalid_q;
  assign wready  = awvalid && !bvalid_q;
  assign arready = !rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      base_q   <= '0;
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_fire) begin
        bvalid_q <= 1'b1;
        if (awaddr == OFS_CTRL) en_q <= wdata[0];
        else if (awaddr == OFS_BASE) base_q <= wdata;
      end else if (bready) begin
        bvalid_q <= 1'b0;
      end
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        if (araddr == OFS_CTRL) rdata_q <= {{(ADDR_W-2){1'b0}}, idle, en_q};
        else if (araddr == OFS_BASE) rdata_q <= base_q;
        else rdata_q <= '0;
      end else if (rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid = bvalid_q;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign enable = en_q;
  assign base   = base_q;
endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
  import dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_LEN  = 10,
  parameter int MAX_BURST = 4,
  parameter int BYTES     = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               enable,
  input  logic [ADDR_W-1:0]                  base,
  output logic [ADDR_W-1:0]                  awaddr,
  output logic [7:0]                         awlen,
  output logic                               awvalid,
  input  logic                               awready,
  input  logic                               bvalid,
  input  logic                               burst_done,
  output logic                               feed_active,
  output logic [$clog2(MAX_BURST+1)-1:0]     feed_len,
  output logic                               idle
);
  localparam int LEFT_W = $clog2(DATA_LEN + 1);
  localparam int LEN_W  = $clog2(MAX_BURST + 1);
  localparam int NBURST = (DATA_LEN + MAX_BURST - 1) / MAX_BURST;
  localparam int BC_W   = $clog2(NBURST + 1);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(MAX_BURST * BYTES);

  dma_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEFT_W-1:0] left_q;
  logic [LEN_W-1:0]  blen_q, cur_len;
  logic [BC_W-1:0]   bcnt_q;

  assign cur_len = (left_q > LEFT_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : LEN_W'(left_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      blen_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      if (bvalid) bcnt_q <= bcnt_q + 1'b1;
      case (state_q)
        ST_IDLE: if (enable) begin
          addr_q  <= base;
          left_q  <= LEFT_W'(DATA_LEN);
          bcnt_q  <= '0;
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (awready) begin
          blen_q  <= cur_len;
          left_q  <= left_q - LEFT_W'(cur_len);
          addr_q  <= addr_q + STRIDE;
          state_q <= ST_DATA;
        end
        ST_DATA: if (burst_done) state_q <= (left_q == '0) ? ST_RESP : ST_ADDR;
        ST_RESP: if (bcnt_q == BC_W'(NBURST)) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign awvalid     = (state_q == ST_ADDR);
  assign awaddr      = addr_q;
  assign awlen       = 8'(cur_len - 1'b1);
  assign feed_active = (state_q == ST_DATA);
  assign feed_len    = blen_q;
  assign idle        = (state_q == ST_IDLE);
endmodule

// File: rtl/dma_wfeed.sv
module dma_wfeed #(
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           active,
  input  logic [$clog2(MAX_BURST+1)-1:0] blen,
  input  logic [DATA_W-1:0]              st_data,
  input  logic                           st_valid,
  output logic                           st_ready,
  output logic [DATA_W-1:0]              wdata,
  output logic                           wvalid,
  output logic                           wlast,
  input  logic                           wready,
  output logic                           done
);
  localparam int LEN_W = $clog2(MAX_BURST + 1);

  logic [LEN_W-1:0] beat_q;
  logic             fire;

  assign wvalid   = active && st_valid;
  assign st_ready = active && wready;
  assign wdata    = st_data;
  assign wlast    = (beat_q == blen - 1'b1);
  assign fire     = wvalid && wready;
  assign done     = fire && wlast;

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else if (done) beat_q <= '0;
    else if (fire) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/stream_dma_writer.sv
module stream_dma_writer
  import dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LITE_AW   = 4,
  parameter int DATA_LEN  = 10,
  parameter int MAX_BURST = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LITE_AW-1:0]    cfg_awaddr,
  input  logic                  cfg_awvalid,
  output logic                  cfg_awready,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  input  logic                  cfg_wvalid,
  output logic                  cfg_wready,
  output logic [1:0]            cfg_bresp,
  output logic                  cfg_bvalid,
  input  logic                  cfg_bready,
  input  logic [LITE_AW-1:0]    cfg_araddr,
  input  logic                  cfg_arvalid,
  output logic                  cfg_arready,
  output logic [ADDR_W-1:0]     cfg_rdata,
  output logic [1:0]            cfg_rresp,
  output logic                  cfg_rvalid,
  input  logic                  cfg_rready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  input  logic [DATA_W-1:0]     st_data,
  input  logic                  st_valid,
  output logic                  st_ready
);
  localparam int BYTES = DATA_W / 8;
  localparam int LEN_W = $clog2(MAX_BURST + 1);

  logic              run_idle, enable, feed_active, burst_done;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  feed_len;

  dma_regs #(.ADDR_W(ADDR_W), .LITE_AW(LITE_AW)) u_regs (
    .clk(clk), .rst(rst),
    .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
    .wdata(cfg_wdata), .wvalid(cfg_wvalid), .wready(cfg_wready),
    .bvalid(cfg_bvalid), .bready(cfg_bready),
    .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
    .rdata(cfg_rdata), .rvalid(cfg_rvalid), .rready(cfg_rready),
    .idle(run_idle), .enable(enable), .base(base)
  );

  dma_burst_ctl #(.ADDR_W(ADDR_W), .DATA_LEN(DATA_LEN), .MAX_BURST(MAX_BURST),
                  .BYTES(BYTES)) u_ctl (
    .clk(clk), .rst(rst), .enable(enable), .base(base),
    .awaddr(m_awaddr), .awlen(m_awlen), .awvalid(m_awvalid), .awready(m_awready),
    .bvalid(m_bvalid), .burst_done(burst_done),
    .feed_active(feed_active), .feed_len(feed_len), .idle(run_idle)
  );

  dma_wfeed #(.DATA_W(DATA_W), .MAX_BURST(MAX_BURST)) u_feed (
    .clk(clk), .rst(rst), .active(feed_active), .blen(feed_len),
    .st_data(st_data), .st_valid(st_valid), .st_ready(st_ready),
    .wdata(m_wdata), .wvalid(m_wvalid), .wlast(m_wlast), .wready(m_wready),
    .done(burst_done)
  );

  assign cfg_bresp = RESP_OKAY;
  assign cfg_rresp = RESP_OKAY;
  assign m_awsize  = 3'($clog2(BYTES));
  assign m_awburst = BURST_INCR;
  assign m_wstrb   = '1;
  assign m_bready  = 1'b1;
endmodule

// File: rtl/dma_writer_checker.sv
module dma_writer_checker #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic [1:0]        m_awburst,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast,
  input logic              st_ready,
  input logic              run_idle,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              cfg_rvalid,
  input logic              cfg_rready
);
  logic [8:0] beats_q;
  logic [7:0] len_q;
  logic       in_burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats_q    <= '0;
      len_q      <= '0;
      in_burst_q <= 1'b0;
    end else begin
      if (m_awvalid && m_awready) begin
        len_q      <= m_awlen;
        in_burst_q <= 1'b1;
      end
      if (m_wvalid && m_wready) begin
        if (m_wlast) begin
          beats_q    <= '0;
          in_burst_q <= 1'b0;
        end else begin
          beats_q <= beats_q + 1'b1;
        end
      end
    end
  end

  assert_len_cap_R5: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> (m_awlen < 8'(MAX_BURST)) && (m_awburst == 2'b01));

  assert_aw_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

  assert_wlast_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (m_wvalid && m_wready && m_wlast) |-> (beats_q == {1'b0, len_q}));

  assert_w_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
    m_wvalid |-> in_burst_q);

  assert_feed_gate_R8: assert property (@(posedge clk) disable iff (rst)
    st_ready |-> !run_idle);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_rvalid && !cfg_rready) |=> cfg_rvalid && $stable(cfg_rdata));
endmodule

bind stream_dma_writer dma_writer_checker #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) i_chk (
  .clk(clk), .rst(rst),
  .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awburst(m_awburst),
  .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
  .st_ready(st_ready), .run_idle(run_idle),
  .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .cfg_rready(cfg_rready)
);

// File: tb/test_stream_dma_writer.sv
`timescale 1ns/1ps
module test_stream_dma_writer;
  localparam int AW = 32, DW = 32, LAW = 4, DLEN = 10, MAXB = 4;
  localparam int NB = (DLEN + MAXB - 1) / MAXB;
  localparam int STEP = MAXB * (DW / 8);

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [LAW-1:0] cfg_awaddr = '0, cfg_araddr = '0;
  logic cfg_awvalid = 0, cfg_wvalid = 0, cfg_arvalid = 0;
  logic cfg_bready = 1'b1, cfg_rready = 1'b1;
  logic [AW-1:0] cfg_wdata = '0;
  logic cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
  logic [1:0] cfg_bresp, cfg_rresp;
  logic [AW-1:0] cfg_rdata;
  logic [AW-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic m_awvalid, m_wlast, m_wvalid, m_bready, st_ready;
  logic m_awready = 0, m_wready = 0, m_bvalid = 0, st_valid = 0;
  logic [DW-1:0] m_wdata, st_data;
  logic [DW/8-1:0] m_wstrb;

  stream_dma_writer #(.ADDR_W(AW), .DATA_W(DW), .LITE_AW(LAW), .DATA_LEN(DLEN),
                      .MAX_BURST(MAXB)) i_stream_dma_writer (
    .clk(clk), .rst(rst),
    .cfg_awaddr(cfg_awaddr), .cfg_awvalid(cfg_awvalid), .cfg_awready(cfg_awready),
    .cfg_wdata(cfg_wdata), .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready),
    .cfg_bresp(cfg_bresp), .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready),
    .cfg_araddr(cfg_araddr), .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready),
    .cfg_rdata(cfg_rdata), .cfg_rresp(cfg_rresp), .cfg_rvalid(cfg_rvalid),
    .cfg_rready(cfg_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .st_data(st_data), .st_valid(st_valid), .st_ready(st_ready)
  );

  int chk = 0, fl = 0, mchk = 0, mfl = 0;
  int cyc = 0, mode = 0, bdel = 0;
  int mon_rem = 0, mon_bidx = 0, mon_len = 0, mon_beats = 0;
  int total_words = 0, total_b = 0, total_aw = 0, runs = 0, pend = 0;
  logic in_burst = 1'b0;
  logic [AW-1:0] cur_base = '0;
  logic [DW-1:0] exp_seq = '0, src_seq = '0;
  logic done = 1'b0;

  assign st_data = src_seq;

  // Slave and source stimulus, driven away from the active edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    m_awready <= ((cyc % 3) != (mode % 3));
    m_wready  <= (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) != 0);
    st_valid  <= ((cyc % 5) != 1);
    m_bvalid  <= (pend > 0) && ((cyc % (bdel + 1)) == 0);
  end

  // Bus monitor: scoreboard of address, data, response traffic.
  always @(posedge clk) begin
    if (!rst) begin
      if (st_ready && !in_burst) begin
        mfl++; $display("FAIL R8: st_ready=1 outside a data phase (exp 0)");
      end
      mchk++;
      if (m_awvalid && m_awready) begin
        int exp_len;
        if (mon_rem == 0) begin mon_rem = DLEN; mon_bidx = 0; runs++; end
        exp_len = (mon_rem > MAXB) ? MAXB : mon_rem;
        mchk += 4;
        if (m_awaddr != cur_base + AW'(mon_bidx * STEP)) begin
          mfl++; $display("FAIL R6: awaddr=%h exp=%h", m_awaddr, cur_base + AW'(mon_bidx * STEP));
        end
        if (int'(m_awlen) != exp_len - 1) begin
          mfl++; $display("FAIL R5: awlen=%0d exp=%0d", m_awlen, exp_len - 1);
        end
        if (m_awburst != 2'b01) begin mfl++; $display("FAIL R5: awburst=%b exp=01", m_awburst); end
        if (m_awsize != 3'd2) begin mfl++; $display("FAIL R5: awsize=%0d exp=2", m_awsize); end
        mon_len = exp_len; mon_rem -= exp_len; mon_bidx++; mon_beats = 0;
        in_burst = 1'b1; total_aw++;
      end
      if (m_wvalid && m_wready) begin
        mon_beats++;
        mchk += 3;
        if (m_wdata != exp_seq) begin
          mfl++; $display("FAIL R7: wdata=%h exp=%h", m_wdata, exp_seq);
        end
        if (m_wlast != (mon_beats == mon_len)) begin
          mfl++; $display("FAIL R7: wlast=%b exp=%b (beat %0d of %0d)", m_wlast,
                          (mon_beats == mon_len), mon_beats, mon_len);
        end
        if (m_wstrb != '1) begin mfl++; $display("FAIL R7: wstrb=%h exp=f", m_wstrb); end
        exp_seq = exp_seq + 1'b1;
        src_seq <= src_seq + 1'b1;
        total_words++;
        if (m_wlast) begin in_burst = 1'b0; pend++; end
      end
      if (m_bvalid && m_bready) begin pend--; total_b++; end
    end
  end

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    chk++;
    if (!ok) begin fl++; $display("FAIL %s: actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic reg_write(input logic [LAW-1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_awaddr = a; cfg_wdata = d; cfg_awvalid = 1; cfg_wvalid = 1;
    while (!cfg_awready) @(negedge clk);
    @(negedge clk);
    cfg_awvalid = 0; cfg_wvalid = 0;
    while (!cfg_bvalid) @(negedge clk);
    check(cfg_bresp == 2'b00, "R12", AW'(cfg_bresp), '0);
  endtask

  task automatic reg_read(input logic [LAW-1:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    cfg_araddr = a; cfg_arvalid = 1;
    while (!cfg_arready) @(negedge clk);
    @(negedge clk);
    cfg_arvalid = 0;
    while (!cfg_rvalid) @(negedge clk);
    d = cfg_rdata;
    check(cfg_rresp == 2'b00, "R12", AW'(cfg_rresp), '0);
  endtask

  task automatic wait_idle();
    logic [AW-1:0] v;
    for (int i = 0; i < 400; i++) begin
      reg_read(4'h0, v);
      if (v[1]) return;
    end
    check(1'b0, "R10", v, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fl++; $display("FAIL watchdog: run hung (actual=expired expected=done)");
    $display("[TB] %0d tests run, %0d failed", chk + mchk, fl + mfl);
    $finish;
  end

  initial begin
    logic [AW-1:0] v;
    int w0, b0, a0, r0, n;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(!st_ready && !m_awvalid && !m_wvalid, "R1", AW'({st_ready, m_awvalid, m_wvalid}), '0);
    reg_read(4'h0, v); check(v == 32'h2, "R1", v, 32'h2);

    reg_write(4'h4, 32'h1234_5670); cur_base = 32'h1234_5670;
    reg_read(4'h4, v); check(v == 32'h1234_5670, "R3", v, 32'h1234_5670);
    reg_read(4'h8, v); check(v == 0, "R3", v, 0);
    reg_write(4'h0, 32'h2);
    repeat (5) @(negedge clk);
    reg_read(4'h0, v); check(v == 32'h2, "R2", v, 32'h2);
    check(total_aw == 0, "R2", AW'(total_aw), 0);

    for (int k = 0; k < 9; k++) begin
      mode = k % 3; bdel = k / 3;
      reg_write(4'h4, 32'h1000 + AW'(k) * 32'h100); cur_base = 32'h1000 + AW'(k) * 32'h100;
      w0 = total_words; b0 = total_b;
      reg_write(4'h0, 32'h1);
      reg_read(4'h0, v); check(v[1:0] == 2'b01, "R4", v, 32'h1);
      reg_write(4'h0, 32'h0);
      wait_idle();
      check(total_words - w0 == DLEN, "R10", AW'(total_words - w0), DLEN);
      check(total_b - b0 == NB && pend == 0, "R9", AW'(total_b - b0), NB);
      a0 = total_aw;
      repeat (30) @(negedge clk);
      check(total_aw == a0, "R10", AW'(total_aw), AW'(a0));
      reg_read(4'h0, v); check(v == 32'h2, "R10", v, 32'h2);
    end

    mode = 1; bdel = 1;
    reg_write(4'h4, 32'h8000); cur_base = 32'h8000;
    w0 = total_words; r0 = runs;
    reg_write(4'h0, 32'h1);
    n = 0;
    while (runs < r0 + 3 && n < 2000) begin @(negedge clk); n++; end
    check(runs >= r0 + 3, "R11", AW'(runs - r0), 3);
    reg_write(4'h0, 32'h0);
    wait_idle();
    check(total_words - w0 == (runs - r0) * DLEN, "R11", AW'(total_words - w0),
          AW'((runs - r0) * DLEN));

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", chk + mchk, fl + mfl);
    $finish;
  end
endmodule